// File: doc/BRIEF.md
# Debug Access Port Protection Gate

This block sits behind the serial-wire link layer of a debug subsystem. It takes decoded register requests and routes them to one of three targets: the debug-port registers, a memory access port or a control access port. Each request carries a debug-port flag, an access-port index, a word-aligned register offset, a read/write flag and write data. A response follows exactly one cycle later. A small stub register file stands in for the real memory bus behind the memory port.

A protection configuration word comes from external non-volatile storage. The block samples it only while the debug-domain reset is held, and the result stays fixed until the next reset. While protection is on, every read of the memory port returns one fixed blocked pattern, and writes to it are discarded. The debug-port registers and the control port work normally in both states. A command written to the control port asks the storage to erase the protection word. Protection is then lifted on the next debug-domain reset.

Top module: `dbg_ap_gate`

## Requirements
- R1: Every cycle with `req_valid_i` high is followed, one clock later, by exactly one cycle of `rsp_valid_o` high. `rsp_valid_o` is low in every other cycle, including during and just after reset.
- R2: With protection off, a read of memory port (index 0) at offset 0xFC returns 0x24770011.
- R3: With protection off, memory-port offsets 0x00 up to 4*(NREG-1) read back the last value written there. Any other offset except 0xFC reads 0x00000000.
- R4: Protection is on when the configuration word sampled while `rst_n` is low equals PROT_ON (default 0xFFFFFF00). Changes to the word after reset release have no effect until the next reset. The control-port status register at offset 0x0C shows the state in bit 0 (1 = protected).
- R5: With protection on, a read of any memory-port offset, including 0xFC, returns 0x23000000.
- R6: With protection on, writes to the memory port change no stored value.
- R7: A read of control port (index 1) at offset 0xFC returns 0x02880000, whether protection is on or off. Offsets other than 0xFC and 0x0C read 0.
- R8: A write to control-port offset 0x04 with bit 0 set makes `prot_clear_o` high for one cycle, aligned with the response. Any other request leaves `prot_clear_o` low.
- R9: A read of any access-port index other than 0 or 1 returns 0x00000000. A write to such an index changes no state.
- R10: Debug-port registers are unaffected by protection. Offset 0x00 reads DP_ID (default 0x0DB60001). Offset 0x04 is a read/write word that is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug-domain clock |
| rst_n | input | 1 | Debug-domain reset, active low, synchronous; the protection word is sampled while it is low |
| prot_cfg_i | input | 32 | Protection configuration word from storage |
| req_valid_i | input | 1 | Request strobe |
| req_dp_i | input | 1 | 1 = debug-port register, 0 = access port |
| req_ap_i | input | 8 | Access-port index |
| req_ofs_i | input | 8 | Word-aligned register offset |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data, valid with the response strobe on reads |
| prot_clear_o | output | 1 | One-cycle request to erase the protection word |

## Verification
On every cycle, the assertions check the following: the one-cycle response timing, the blocked pattern on protected memory reads, the fixed control-port and debug-port identification values, zero data from unimplemented ports, the origin of every erase pulse, a latched protection state that does not move between resets, and stored memory words that do not change under protected writes. Some behaviour shows up only across several requests and resets, so only the bench scenarios can show it. These cases are: write data surviving a protected period and reading back after unprotection, the erase request reaching storage and lifting protection at the next reset but not before, and configuration changes after reset release being ignored.

// File: rtl/dbg_ap_pkg.sv
package dbg_ap_pkg;
   localparam logic [5:0]  IDX_IDR      = 6'h3F;
   localparam logic [5:0]  IDX_ERASE    = 6'h01;
   localparam logic [5:0]  IDX_STATUS   = 6'h03;
   localparam logic [5:0]  IDX_DP_ID    = 6'h00;
   localparam logic [5:0]  IDX_DP_SCR   = 6'h01;
   localparam logic [7:0]  AP_MEM       = 8'd0;
   localparam logic [7:0]  AP_CTRL      = 8'd1;
   localparam logic [31:0] MEM_IDR_VAL  = 32'h2477_0011;
   localparam logic [31:0] CTRL_IDR_VAL = 32'h0288_0000;
   localparam logic [31:0] BLOCKED_VAL  = 32'h2300_0000;

   typedef enum logic [1:0] {TGT_DP, TGT_MEM, TGT_CTRL, TGT_NONE} tgt_e;
endpackage

// File: rtl/dbg_prot_latch.sv
module dbg_prot_latch #(
   parameter int          CW      = 32,
   parameter logic [31:0] PROT_ON = 32'hFFFF_FF00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_i,
   output logic          prot_o
);
   localparam logic [CW-1:0] ON_VAL = CW'(PROT_ON);

   always_ff @(posedge clk) begin
      if (!rst_n) prot_o <= (cfg_i == ON_VAL);
   end

   // R4: protection state is frozen between resets
   a_r4_held: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(prot_o));
endmodule

// File: rtl/dbg_mem_ap_stub.sv
module dbg_mem_ap_stub
   import dbg_ap_pkg::*;
#(
   parameter int NREG = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        prot_i,
   input  logic        wr_en_i,
   input  logic [5:0]  idx_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] rdata_o
);
   logic [31:0] regs [NREG];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREG; i++) begin
         if (wr_en_i && !prot_i && idx_i == 6'(i)) regs[i] <= wdata_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (prot_i)                rdata_o = BLOCKED_VAL;
      else if (idx_i == IDX_IDR) rdata_o = MEM_IDR_VAL;
      else begin
         for (int i = 0; i < NREG; i++) begin
            if (idx_i == 6'(i)) rdata_o = regs[i];
         end
      end
   end

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_hold
         // R6: protected writes leave each stored word untouched
         a_r6_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
            (prot_i && wr_en_i) |=> $stable(regs[g]));
      end
   endgenerate
endmodule

// File: rtl/dbg_ctrl_ap.sv
module dbg_ctrl_ap
   import dbg_ap_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        prot_i,
   input  logic        wr_en_i,
   input  logic [5:0]  idx_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] rdata_o,
   output logic        clear_o
);
   always_comb begin
      unique case (idx_i)
         IDX_IDR:    rdata_o = CTRL_IDR_VAL;
         IDX_STATUS: rdata_o = {31'b0, prot_i};
         default:    rdata_o = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) clear_o <= 1'b0;
      else        clear_o <= wr_en_i && (idx_i == IDX_ERASE) && wdata_i[0];
   end
endmodule

// File: rtl/dbg_ap_gate.sv
module dbg_ap_gate
   import dbg_ap_pkg::*;
#(
   parameter int          NREG    = 4,
   parameter logic [31:0] PROT_ON = 32'hFFFF_FF00,
   parameter logic [31:0] DP_ID   = 32'h0DB6_0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] prot_cfg_i,
   input  logic        req_valid_i,
   input  logic        req_dp_i,
   input  logic [7:0]  req_ap_i,
   input  logic [7:0]  req_ofs_i,
   input  logic        req_write_i,
   input  logic [31:0] req_wdata_i,
   output logic        rsp_valid_o,
   output logic [31:0] rsp_rdata_o,
   output logic        prot_clear_o
);
   localparam int MAX_REG = 63;

   generate
      if (NREG < 1 || NREG > MAX_REG) begin : g_bad_nreg
         $error("NREG must lie in 1..63 so the stub never reaches the identification slot");
      end
      if (PROT_ON == 32'hFFFF_FFFF) begin : g_bad_on
         $error("PROT_ON must differ from the erased word");
      end
   endgenerate

   logic        prot;
   logic [5:0]  idx;
   tgt_e        tgt;
   logic [31:0] mem_rdata, ctrl_rdata, dp_scr, rd_mux;

   assign idx = req_ofs_i[7:2];

   always_comb begin
      if (req_dp_i)                tgt = TGT_DP;
      else if (req_ap_i == AP_MEM)  tgt = TGT_MEM;
      else if (req_ap_i == AP_CTRL) tgt = TGT_CTRL;
      else                          tgt = TGT_NONE;
   end

   dbg_prot_latch #(.CW(32), .PROT_ON(PROT_ON)) u_latch (
      .clk(clk), .rst_n(rst_n), .cfg_i(prot_cfg_i), .prot_o(prot));

   dbg_mem_ap_stub #(.NREG(NREG)) u_mem (
      .clk(clk), .rst_n(rst_n), .prot_i(prot),
      .wr_en_i(req_valid_i && req_write_i && tgt == TGT_MEM),
      .idx_i(idx), .wdata_i(req_wdata_i), .rdata_o(mem_rdata));

   dbg_ctrl_ap u_ctrl (
      .clk(clk), .rst_n(rst_n), .prot_i(prot),
      .wr_en_i(req_valid_i && req_write_i && tgt == TGT_CTRL),
      .idx_i(idx), .wdata_i(req_wdata_i), .rdata_o(ctrl_rdata),
      .clear_o(prot_clear_o));

   always_ff @(posedge clk) begin
      if (!rst_n) dp_scr <= '0;
      else if (req_valid_i && req_write_i && tgt == TGT_DP && idx == IDX_DP_SCR)
         dp_scr <= req_wdata_i;
   end

   always_comb begin
      unique case (tgt)
         TGT_DP:   rd_mux = (idx == IDX_DP_ID) ? DP_ID :
                            (idx == IDX_DP_SCR) ? dp_scr : '0;
         TGT_MEM:  rd_mux = mem_rdata;
         TGT_CTRL: rd_mux = ctrl_rdata;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_rdata_o <= '0;
      end else begin
         rsp_valid_o <= req_valid_i;
         rsp_rdata_o <= (req_valid_i && !req_write_i) ? rd_mux : '0;
      end
   end

   // R1: one response per request, one cycle later
   a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> rsp_valid_o);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> !rsp_valid_o);
   // R5: protected memory reads see the blocked pattern
   a_r5_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid_i && !req_write_i && !req_dp_i && req_ap_i == AP_MEM && prot)
      |-> rsp_rdata_o == BLOCKED_VAL);
   // R7: control-port identification never changes
   a_r7_ctrl_id: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid_i && !req_write_i && !req_dp_i && req_ap_i == AP_CTRL && idx == IDX_IDR)
      |-> rsp_rdata_o == CTRL_IDR_VAL);
   // R8: an erase pulse comes only from an erase command
   a_r8_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
      prot_clear_o |-> $past(req_valid_i && req_write_i && !req_dp_i &&
                             req_ap_i == AP_CTRL && idx == IDX_ERASE && req_wdata_i[0]));
   // R9: unimplemented ports read as zero
   a_r9_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid_i && !req_write_i && !req_dp_i && req_ap_i > AP_CTRL)
      |-> rsp_rdata_o == 32'h0);
   // R10: debug-port identification holds regardless of protection
   a_r10_dp_id: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid_i && !req_write_i && req_dp_i && idx == IDX_DP_ID)
      |-> rsp_rdata_o == DP_ID);
endmodule

// File: tb/sim_dbg_ap_gate.sv
`timescale 1ns/1ps
module sim_dbg_ap_gate;
   localparam int          NREG    = 4;
   localparam logic [31:0] PROT_ON = 32'hFFFF_FF00;
   localparam logic [31:0] DP_ID   = 32'h0DB6_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] prot_cfg_i = 32'hFFFF_FFFF;
   logic        req_valid_i = 1'b0, req_dp_i = 1'b0, req_write_i = 1'b0;
   logic [7:0]  req_ap_i = '0, req_ofs_i = '0;
   logic [31:0] req_wdata_i = '0;
   logic        rsp_valid_o, prot_clear_o;
   logic [31:0] rsp_rdata_o;

   int checks = 0, failures = 0;

   logic [31:0] m_mem [NREG];
   logic [31:0] m_scr;
   logic        m_prot;

   always #2 clk = ~clk;

   dbg_ap_gate #(.NREG(NREG), .PROT_ON(PROT_ON), .DP_ID(DP_ID)) u0 (
      .clk(clk), .rst_n(rst_n), .prot_cfg_i(prot_cfg_i),
      .req_valid_i(req_valid_i), .req_dp_i(req_dp_i), .req_ap_i(req_ap_i),
      .req_ofs_i(req_ofs_i), .req_write_i(req_write_i), .req_wdata_i(req_wdata_i),
      .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .prot_clear_o(prot_clear_o));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input bit dp, input logic [7:0] ap, input logic [7:0] ofs);
      logic [5:0] ix = ofs[7:2];
      if (dp) return (ix == 0) ? DP_ID : (ix == 1) ? m_scr : 32'h0;
      if (ap == 0) begin
         if (m_prot)    return 32'h2300_0000;
         if (ix == 63)  return 32'h2477_0011;
         if (ix < NREG) return m_mem[ix];
         return 32'h0;
      end
      if (ap == 1) return (ix == 63) ? 32'h0288_0000 : (ix == 3) ? {31'b0, m_prot} : 32'h0;
      return 32'h0;
   endfunction

   function automatic string tag_of(input bit dp, input logic [7:0] ap, input logic [7:0] ofs);
      if (dp) return "R10";
      if (ap == 0) return m_prot ? "R5" : (ofs == 8'hFC) ? "R2" : "R3";
      if (ap == 1) return (ofs == 8'h0C) ? "R4" : "R7";
      return "R9";
   endfunction

   // call at a falling edge; returns at the next falling edge
   task automatic xact(input bit dp, input logic [7:0] ap, input logic [7:0] ofs,
                       input bit wr, input logic [31:0] wd);
      logic [31:0] e;
      bit          erase;
      e     = exp_rd(dp, ap, ofs);
      erase = wr && !dp && ap == 1 && ofs[7:2] == 1 && wd[0];
      req_valid_i = 1; req_dp_i = dp; req_ap_i = ap; req_ofs_i = ofs;
      req_write_i = wr; req_wdata_i = wd;
      @(negedge clk);
      req_valid_i = 0;
      chk(rsp_valid_o === 1'b1, "R1 response strobe", {31'b0, rsp_valid_o}, 32'h1);
      if (!wr) chk(rsp_rdata_o === e, tag_of(dp, ap, ofs), rsp_rdata_o, e);
      chk(prot_clear_o === erase, "R8 erase pulse", {31'b0, prot_clear_o}, {31'b0, erase});
      if (prot_clear_o) prot_cfg_i = 32'hFFFF_FFFF;
      if (wr) begin
         if (dp && ofs[7:2] == 1) m_scr = wd;
         if (!dp && ap == 0 && !m_prot && ofs[7:2] < NREG) m_mem[ofs[7:2]] = wd;
      end
   endtask

   task automatic dbg_reset(input logic [31:0] cfg);
      prot_cfg_i = cfg;
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk(rsp_valid_o === 1'b0, "R1 idle in reset", {31'b0, rsp_valid_o}, 32'h0);
      rst_n = 1;
      m_prot = (cfg == PROT_ON);
      m_scr  = '0;
      @(negedge clk);
      chk(rsp_valid_o === 1'b0, "R1 idle after reset", {31'b0, rsp_valid_o}, 32'h0);
      xact(0, 8'd1, 8'h0C, 0, 0);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      void'($urandom(32'd20240517));
      @(negedge clk);
      dbg_reset(32'hFFFF_FFFF);
      // directed: identification values and stub contents unprotected
      xact(0, 8'd0, 8'hFC, 0, 0);
      xact(0, 8'd1, 8'hFC, 0, 0);
      xact(1, 8'd0, 8'h00, 0, 0);
      for (int i = 0; i < NREG; i++) xact(0, 8'd0, 8'(i * 4), 1, 32'hA5A5_0000 + i);
      for (int i = 0; i < NREG; i++) xact(0, 8'd0, 8'(i * 4), 0, 0);
      xact(0, 8'd0, 8'(NREG * 4), 0, 0);
      // R9: unimplemented index write then read
      xact(0, 8'd2, 8'h00, 1, 32'hDEAD_BEEF);
      xact(0, 8'd255, 8'hFC, 0, 0);
      xact(0, 8'd0, 8'h00, 0, 0);
      // R4/R5/R6: protect, attempt writes, cfg change after release ignored
      dbg_reset(PROT_ON);
      xact(0, 8'd0, 8'hFC, 0, 0);
      xact(0, 8'd0, 8'h00, 1, 32'h1111_1111);
      xact(0, 8'd1, 8'hFC, 0, 0);
      xact(1, 8'd0, 8'h04, 1, 32'h7777_0001);
      xact(1, 8'd0, 8'h04, 0, 0);
      prot_cfg_i = 32'hFFFF_FFFF;
      repeat (2) @(negedge clk);
      xact(0, 8'd1, 8'h0C, 0, 0);
      xact(0, 8'd0, 8'h04, 0, 0);
      // R8: erase command with bit 0 clear does nothing, set requests erase
      prot_cfg_i = PROT_ON;
      xact(0, 8'd1, 8'h04, 1, 32'h0000_0002);
      xact(0, 8'd1, 8'h04, 1, 32'h0000_0001);
      chk(prot_cfg_i == 32'hFFFF_FFFF, "R8 storage erased", prot_cfg_i, 32'hFFFF_FFFF);
      xact(0, 8'd1, 8'h0C, 0, 0);   // still protected until reset
      dbg_reset(prot_cfg_i);
      for (int i = 0; i < NREG; i++) xact(0, 8'd0, 8'(i * 4), 0, 0); // R6 old data
      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [7:0] ap, ofs;
         bit dp, wr;
         if (n % 75 == 74) begin
            v = $urandom % 3;
            dbg_reset(v == 0 ? PROT_ON : v == 1 ? 32'hFFFF_FFFF : $urandom);
         end
         dp = ($urandom % 6) == 0;
         v = $urandom % 8;
         ap = (v < 3) ? 8'd0 : (v < 6) ? 8'd1 : 8'($urandom);
         v = $urandom % 6;
         ofs = (v == 0) ? 8'hFC : (v == 5) ? {6'($urandom), 2'b00} : 8'((v - 1) * 4);
         wr = ($urandom % 3) == 0;
         xact(dp, ap, ofs, wr, $urandom);
         if ((n % 10) == 0) begin
            @(negedge clk);
            chk(rsp_valid_o === 1'b0, "R1 no response when idle", {31'b0, rsp_valid_o}, 32'h0);
         end
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule